// File: doc/BRIEF.md
# Multicycle Processor Core with Upper-Immediate and Inline-Constant Loads

This block is a 32-bit multicycle processor core in the classic load/store style. A finite-state-machine controller steps each instruction through a few short cycles. It shares one memory port between instruction fetch and data access. The datapath holds these registers:

- the program counter
- an instruction register
- a memory data register
- two operand registers
- an ALU result register
- a 32-entry register file with two read ports

The core runs word loads and stores, register-to-register arithmetic, branch-if-equal and absolute jumps. It also runs two constant-loading instructions:

- **Load-upper** places a 16-bit immediate in the high half of a register and zeroes the low half. It finishes in three cycles.
- **Load-constant** takes the whole 32-bit word stored right after the instruction and writes it to a register. The program counter then steps past that word, so execution resumes two words after the instruction.

Memory sits outside the core and has a combinational read. It sees a byte address whose two low bits are always zero. A write happens on the clock edge while the write strobe is high. The controller's state code is brought out, so the cycle count of each instruction can be measured at the ports. The fetch state has code 0.

Top module: `mc_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the state code is 0 (fetch) and the memory address is the reset PC (0). Every fetch cycle is followed by state code 1 (decode).
- R2: Load-upper (opcode 0x0F, target field bits 20:16, immediate bits 15:0) writes {imm, 16'h0000} to the target register and takes exactly 3 cycles from fetch to the next fetch.
- R3: Load-constant (opcode 0x31, target bits 20:16) writes the memory word at instruction address + 4 into the target register. It takes 4 cycles, and the next fetch is at instruction address + 8.
- R4: A word load (opcode 0x23) reads memory at base register (bits 25:21) + sign-extended offset into the target register and takes 5 cycles.
- R5: A word store (opcode 0x2B) writes the target register to base + sign-extended offset and takes 4 cycles.
- R6: Register-type instructions (opcode 0x00, destination bits 15:11, function bits 5:0 with 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than) write the result and take 4 cycles.
- R7: Branch-if-equal (opcode 0x04) takes 3 cycles. When taken it continues at instruction address + 4 + offset*4. When not taken it continues at instruction address + 4, and the skipped instruction has no effect on memory.
- R8: A jump (opcode 0x02) takes 3 cycles and continues at {PC+4 bits 31:28, index bits 25:0, 2'b00}.
- R9: Register 0 always reads as zero; writes to it have no effect.
- R10: The write strobe is high for exactly one cycle per store, only in the store-access state, and never for any other instruction.
- R11: Any other opcode takes 2 cycles, changes no register or memory, and is followed by a fetch at instruction address + 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| memRdata | input | 32 | Read data from the shared memory for the current address |
| memAddr | output | 32 | Byte address for the shared memory (PC or computed data address) |
| memWdata | output | 32 | Store data |
| memWe | output | 1 | Memory write strobe, one cycle per store |
| stateCode | output | 4 | Current controller state (0 = fetch, 1 = decode) |

## Verification
A wrong controller transition shows up at once on the state code. It also shifts the fetch address on the memory port by the next fetch, so the per-instruction cycle counts and the fetch-address sequence catch it within one instruction. A wrong datapath value, such as a bad write-back selection, a missed PC step after the inline constant, or a write to register 0, shows up later. It becomes visible only when a following store places that register on the data lines. For that reason the program stores every result it computes, and the bench compares the final memory image with values it computes on its own.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [3:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_MEMADR = 4'd2,
    S_MEMRD  = 4'd3,
    S_MEMWB  = 4'd4,
    S_MEMWR  = 4'd5,
    S_RTEXE  = 4'd6,
    S_RTWB   = 4'd7,
    S_BEQ    = 4'd8,
    S_JMP    = 4'd9,
    S_LUIWB  = 4'd10,
    S_LDIRD  = 4'd11,
    S_LDIWB  = 4'd12
  } state_e;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JMP   = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_LDI   = 6'h31;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_FUNCT = 2'd2} aluop_e;
  typedef enum logic [1:0] {SRCB_REG = 2'd0, SRCB_FOUR = 2'd1, SRCB_IMM = 2'd2, SRCB_IMMW = 2'd3} srcb_e;
  typedef enum logic [1:0] {WB_ALU = 2'd0, WB_MDR = 2'd1, WB_UPPER = 2'd2} wbsel_e;
  typedef enum logic [1:0] {PCS_ALU = 2'd0, PCS_ALUOUT = 2'd1, PCS_JUMP = 2'd2} pcsrc_e;

  typedef struct packed {
    logic    pcWrite;
    logic    pcWriteCond;
    logic    addrFromAlu;
    logic    memWrite;
    logic    irWrite;
    logic    dstFromRd;
    wbsel_e  wbSel;
    logic    regWrite;
    logic    srcAFromReg;
    srcb_e   srcB;
    aluop_e  aluOp;
    pcsrc_e  pcSrc;
  } ctrl_t;

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int DW = 32,
  parameter int NREG = 32
) (
  input  logic                     clk,
  input  logic [$clog2(NREG)-1:0]  rdAddrA,
  input  logic [$clog2(NREG)-1:0]  rdAddrB,
  input  logic                     wrEn,
  input  logic [$clog2(NREG)-1:0]  wrAddr,
  input  logic [DW-1:0]            wrData,
  output logic [DW-1:0]            rdDataA,
  output logic [DW-1:0]            rdDataB
);
  localparam int AW = $clog2(NREG);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (wrEn && (wrAddr != '0)) regs[wrAddr] <= wrData;
  end

  assign rdDataA = (rdAddrA == AW'(0)) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == AW'(0)) ? '0 : regs[rdAddrB];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  input  aluop_e        aluOp,
  input  logic [5:0]    funct,
  output logic [DW-1:0] result,
  output logic          isZero
);
  always_comb begin
    unique case (aluOp)
      ALU_SUB: result = opA - opB;
      ALU_FUNCT: begin
        case (funct)
          FN_SUB:  result = opA - opB;
          FN_AND:  result = opA & opB;
          FN_OR:   result = opA | opB;
          FN_SLT:  result = ($signed(opA) < $signed(opB)) ? DW'(1) : '0;
          default: result = opA + opB;
        endcase
      end
      default: result = opA + opB;
    endcase
  end

  assign isZero = (result == '0);
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_t         ctl,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [5:0]    opcode
);
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);
  localparam int HALF = DW / 2;

  logic [DW-1:0] pcQ, irQ, mdrQ, aQ, bQ, aluOutQ;
  logic [DW-1:0] srcA, srcB, aluY, pcNext, wbData, rfA, rfB, immExt;
  logic [RAW-1:0] rsF, rtF, rdF, wrAddr;
  logic aluZero, pcEn;

  assign opcode = irQ[31:26];
  assign rsF    = irQ[25:21];
  assign rtF    = irQ[20:16];
  assign rdF    = irQ[15:11];
  assign immExt = {{(DW-16){irQ[15]}}, irQ[15:0]};

  assign srcA = ctl.srcAFromReg ? aQ : pcQ;

  always_comb begin
    unique case (ctl.srcB)
      SRCB_FOUR: srcB = DW'(4);
      SRCB_IMM:  srcB = immExt;
      SRCB_IMMW: srcB = immExt << 2;
      default:   srcB = bQ;
    endcase
  end

  mc_alu #(.DW(DW)) i_alu (
    .opA(srcA), .opB(srcB), .aluOp(ctl.aluOp), .funct(irQ[5:0]),
    .result(aluY), .isZero(aluZero)
  );

  always_comb begin
    unique case (ctl.pcSrc)
      PCS_ALUOUT: pcNext = aluOutQ;
      PCS_JUMP:   pcNext = {pcQ[DW-1:DW-4], irQ[25:0], 2'b00};
      default:    pcNext = aluY;
    endcase
  end

  assign pcEn = ctl.pcWrite | (ctl.pcWriteCond & aluZero);

  always_comb begin
    unique case (ctl.wbSel)
      WB_MDR:   wbData = mdrQ;
      WB_UPPER: wbData = {irQ[15:0], {HALF{1'b0}}};
      default:  wbData = aluOutQ;
    endcase
  end

  assign wrAddr = ctl.dstFromRd ? rdF : rtF;

  mc_regfile #(.DW(DW), .NREG(NREG)) i_rf (
    .clk(clk), .rdAddrA(rsF), .rdAddrB(rtF),
    .wrEn(ctl.regWrite), .wrAddr(wrAddr), .wrData(wbData),
    .rdDataA(rfA), .rdDataB(rfB)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ     <= RESET_PC;
      irQ     <= '0;
      mdrQ    <= '0;
      aQ      <= '0;
      bQ      <= '0;
      aluOutQ <= '0;
    end else begin
      if (pcEn)        pcQ <= pcNext;
      if (ctl.irWrite) irQ <= memRdata;
      mdrQ    <= memRdata;
      aQ      <= rfA;
      bQ      <= rfB;
      aluOutQ <= aluY;
    end
  end

  assign memAddr  = ctl.addrFromAlu ? aluOutQ : pcQ;
  assign memWdata = bQ;
endmodule

// File: rtl/mc_control.sv
module mc_control
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] opcode,
  output ctrl_t      ctl,
  output logic [3:0] stateCode
);
  state_e stateQ, stateD;

  always_comb begin
    stateD = S_FETCH;
    unique case (stateQ)
      S_FETCH:  stateD = S_DECODE;
      S_DECODE: begin
        case (opcode)
          OP_LW, OP_SW: stateD = S_MEMADR;
          OP_RTYPE:     stateD = S_RTEXE;
          OP_BEQ:       stateD = S_BEQ;
          OP_JMP:       stateD = S_JMP;
          OP_LUI:       stateD = S_LUIWB;
          OP_LDI:       stateD = S_LDIRD;
          default:      stateD = S_FETCH;
        endcase
      end
      S_MEMADR: stateD = (opcode == OP_LW) ? S_MEMRD : S_MEMWR;
      S_MEMRD:  stateD = S_MEMWB;
      S_RTEXE:  stateD = S_RTWB;
      S_LDIRD:  stateD = S_LDIWB;
      default:  stateD = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_FETCH;
    else       stateQ <= stateD;
  end

  always_comb begin
    ctl = '0;
    unique case (stateQ)
      S_FETCH: begin
        ctl.irWrite = 1'b1;
        ctl.srcB    = SRCB_FOUR;
        ctl.pcWrite = 1'b1;
      end
      S_DECODE: ctl.srcB = SRCB_IMMW;
      S_MEMADR: begin
        ctl.srcAFromReg = 1'b1;
        ctl.srcB        = SRCB_IMM;
      end
      S_MEMRD: ctl.addrFromAlu = 1'b1;
      S_MEMWB: begin
        ctl.regWrite = 1'b1;
        ctl.wbSel    = WB_MDR;
      end
      S_MEMWR: begin
        ctl.addrFromAlu = 1'b1;
        ctl.memWrite    = 1'b1;
      end
      S_RTEXE: begin
        ctl.srcAFromReg = 1'b1;
        ctl.aluOp       = ALU_FUNCT;
      end
      S_RTWB: begin
        ctl.regWrite  = 1'b1;
        ctl.dstFromRd = 1'b1;
      end
      S_BEQ: begin
        ctl.srcAFromReg = 1'b1;
        ctl.aluOp       = ALU_SUB;
        ctl.pcWriteCond = 1'b1;
        ctl.pcSrc       = PCS_ALUOUT;
      end
      S_JMP: begin
        ctl.pcWrite = 1'b1;
        ctl.pcSrc   = PCS_JUMP;
      end
      S_LUIWB: begin
        ctl.regWrite = 1'b1;
        ctl.wbSel    = WB_UPPER;
      end
      S_LDIRD: begin
        ctl.srcB    = SRCB_FOUR;
        ctl.pcWrite = 1'b1;
      end
      S_LDIWB: begin
        ctl.regWrite = 1'b1;
        ctl.wbSel    = WB_MDR;
      end
      default: ctl = '0;
    endcase
  end

  assign stateCode = stateQ;
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memWe,
  output logic [3:0]    stateCode
);
  ctrl_t      ctl;
  logic [5:0] opcode;

  mc_control i_ctrl (
    .clk(clk), .rstN(rstN), .opcode(opcode), .ctl(ctl), .stateCode(stateCode)
  );

  mc_datapath #(.DW(DW), .RESET_PC(RESET_PC)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .opcode(opcode)
  );

  assign memWe = ctl.memWrite;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic [3:0]    stateCode,
  input logic          memWe,
  input logic [DW-1:0] memAddr,
  input logic [5:0]    opcode
);
  logic [DW-1:0] fetchAddr;
  logic          knownOp;

  always_ff @(posedge clk) begin
    if (!rstN)                fetchAddr <= '0;
    else if (stateCode == 4'd0) fetchAddr <= memAddr;
  end

  assign knownOp = (opcode == 6'h00) || (opcode == 6'h02) || (opcode == 6'h04) ||
                   (opcode == 6'h0F) || (opcode == 6'h23) || (opcode == 6'h2B) ||
                   (opcode == 6'h31);

  // R1
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateCode == 4'd0 |=> stateCode == 4'd1);

  // R2
  upper_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 4'd1 && opcode == 6'h0F) |=> stateCode == 4'd10);

  // R2
  upper_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateCode == 4'd10 |=> stateCode == 4'd0);

  // R3
  const_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateCode == 4'd11 |=> stateCode == 4'd12);

  // R3
  const_operand_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateCode == 4'd11 |-> memAddr == fetchAddr + DW'(4));

  // R3
  const_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 4'd12) |=> (stateCode == 4'd0 && memAddr == fetchAddr + DW'(8)));

  // R4
  load_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateCode == 4'd3 |=> stateCode == 4'd4);

  // R10
  store_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> stateCode == 4'd5);

  // R10
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R11
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 4'd1 && !knownOp) |=> stateCode == 4'd0);
endmodule

bind mc_core mc_core_chk #(.DW(DW)) i_chk (
  .clk(clk), .rstN(rstN), .stateCode(stateCode), .memWe(memWe),
  .memAddr(memAddr), .opcode(opcode)
);

// File: tb/test_mc_core.sv
module test_mc_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] memRdata, memAddr, memWdata;
  logic        memWe;
  logic [3:0]  stateCode;

  logic [31:0] mem [64];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int weCount = 0;
  bit timedOut = 1'b0;

  always #10 clk = ~clk;

  mc_core i_mc_core (
    .clk(clk), .rstN(rstN), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memWe(memWe), .stateCode(stateCode)
  );

  assign memRdata = mem[memAddr[7:2]];

  always @(posedge clk) begin
    if (memWe) mem[memAddr[7:2]] <= memWdata;
    cycles <= cycles + 1;
    if (cycles > 20000) timedOut <= 1'b1;
  end

  always @(negedge clk) if (rstN && memWe) weCount <= weCount + 1;

  localparam int NV = 23;
  // fetch address, expected cycles of the instruction at that address
  localparam int VADDR [NV] = '{0, 4, 12, 16, 20, 24, 28, 32, 36, 44, 48, 52,
                                56, 64, 68, 72, 76, 80, 84, 88, 92, 96, 96};
  localparam int VCYC  [NV] = '{3, 4, 4, 4, 5, 4, 4, 4, 3, 3, 4, 4,
                                4, 4, 5, 4, 4, 4, 4, 4, 2, 3, 3};
  localparam string VREQ [NV] = '{"R2", "R3", "R6", "R5", "R4", "R6", "R9", "R5",
                                  "R7", "R7", "R6", "R6", "R3", "R5", "R4", "R5",
                                  "R5", "R5", "R5", "R5", "R11", "R8", "R8"};

  function automatic logic [31:0] rt_i(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] im_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walkOne(int addr, int cyc, string req);
    int n;
    while (stateCode != 4'd0 && !timedOut) @(negedge clk);
    check(memAddr == 32'(addr), {req, " fetch address"}, memAddr, 32'(addr));
    n = 1;
    @(negedge clk);
    while (stateCode != 4'd0 && !timedOut) begin
      n++;
      @(negedge clk);
    end
    check(n == cyc, {req, " cycle count"}, 32'(n), 32'(cyc));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[0]  = im_i(6'h0F, 0, 1, 16'h1234);      // r1 = 0x12340000
    mem[1]  = im_i(6'h31, 0, 2, 16'h0);         // r2 = next word
    mem[2]  = 32'h0000_5678;
    mem[3]  = rt_i(1, 2, 3, 6'h25);             // r3 = r1 | r2
    mem[4]  = im_i(6'h2B, 0, 3, 16'h80);        // store r3
    mem[5]  = im_i(6'h23, 0, 4, 16'h80);        // r4 = load
    mem[6]  = rt_i(4, 1, 5, 6'h22);             // r5 = r4 - r1
    mem[7]  = rt_i(1, 1, 0, 6'h20);             // write to r0
    mem[8]  = im_i(6'h2B, 0, 0, 16'h84);        // store r0
    mem[9]  = im_i(6'h04, 5, 2, 16'h1);         // taken branch
    mem[10] = im_i(6'h2B, 0, 1, 16'h88);        // skipped
    mem[11] = im_i(6'h04, 1, 2, 16'h5);         // not taken
    mem[12] = rt_i(2, 1, 6, 6'h2A);             // r6 = slt
    mem[13] = rt_i(3, 2, 7, 6'h24);             // r7 = and
    mem[14] = im_i(6'h31, 0, 8, 16'h0);         // r8 = next word
    mem[15] = 32'hDEAD_BEEF;
    mem[16] = im_i(6'h2B, 0, 8, 16'h8C);
    mem[17] = im_i(6'h23, 0, 9, 16'h3C);        // r9 = mem[15]
    mem[18] = im_i(6'h2B, 0, 6, 16'h90);
    mem[19] = im_i(6'h2B, 0, 7, 16'h94);
    mem[20] = im_i(6'h2B, 0, 9, 16'h98);
    mem[21] = im_i(6'h2B, 0, 4, 16'h9C);
    mem[22] = im_i(6'h2B, 0, 1, 16'hA0);
    mem[23] = 32'hFC00_0000;                    // undefined opcode
    mem[24] = {6'h02, 26'd24};                  // jump to self
    mem[34] = 32'hAAAA_AAAA;                    // sentinel for skipped store

    repeat (3) @(negedge clk);
    // R1: reset state
    check(stateCode == 4'd0, "R1 reset state", 32'(stateCode), 32'd0);
    check(memAddr == 32'd0, "R1 reset address", memAddr, 32'd0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) walkOne(VADDR[v], VCYC[v], VREQ[v]);

    check(mem[32] == 32'h1234_5678, "R6 or result stored", mem[32], 32'h1234_5678);
    check(mem[33] == 32'h0, "R9 r0 stays zero", mem[33], 32'h0);
    check(mem[34] == 32'hAAAA_AAAA, "R7 skipped store", mem[34], 32'hAAAA_AAAA);
    check(mem[35] == 32'hDEAD_BEEF, "R3 inline constant", mem[35], 32'hDEAD_BEEF);
    check(mem[36] == 32'h1, "R6 slt", mem[36], 32'h1);
    check(mem[37] == 32'h5678, "R6 and", mem[37], 32'h5678);
    check(mem[38] == 32'hDEAD_BEEF, "R4 load offset", mem[38], 32'hDEAD_BEEF);
    check(mem[39] == 32'h1234_5678, "R4 load value", mem[39], 32'h1234_5678);
    check(mem[40] == 32'h1234_0000, "R2 upper immediate", mem[40], 32'h1234_0000);
    check(weCount == 8, "R10 store strobe count", 32'(weCount), 32'd8);

    // R1: reset in the middle of the jump loop
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(stateCode == 4'd0, "R1 mid-run reset state", 32'(stateCode), 32'd0);
    check(memAddr == 32'd0, "R1 mid-run reset address", memAddr, 32'd0);
    rstN = 1'b1;
    walkOne(0, 3, "R1 R2 restart");
    walkOne(4, 4, "R1 R3 restart");

    if (timedOut) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule